// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block is a bank of storage elements that doubles as a serial test path. In functional operation every element loads its own parallel input on each clock, so the bank acts as an ordinary register. With test mode raised, a built-in sequencer runs one complete scan test after each start request. It shifts a pattern in from the serial input for exactly as many cycles as the chain has elements. It then gives one functional cycle that captures the parallel inputs, which are the outputs of the surrounding logic. Last, it shifts the captured response out of the serial output over the same number of cycles, and it reports completion with a one-cycle done pulse.

Neither the outside tester nor any other driver toggles a scan-enable. The order of shift-in, capture and shift-out is fixed in hardware. A tester only has to present serial data and read serial data in known cycles, counted from the start request. The serial stream has no valid/ready handshake and no back-pressure, because the sequencer owns the timing. A bit is taken from the serial input on every shift cycle, and the serial output must be read on every shift-out cycle. An overlap option lets the bits shifted in during shift-out serve as the next pattern, so back-to-back tests cost N+1 cycles each instead of 2N+1. The start, done, test-mode and overlap pins are plain levels.

Top module: `scan_seq_top`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every element to 0, returns the sequencer to idle and holds done low; it overrides all other inputs.
- R2: With test_mode low, func_q equals the func_d value present at the previous clock edge, and start has no effect (done stays low).
- R3: With test_mode high and the sequencer idle with start low, func_q holds its value.
- R4: A start sampled high in idle is followed by exactly N shift cycles. In each shift cycle element 0 loads scan_in and element i loads element i-1. The bit driven in shift cycle j (counting from 0) therefore ends in func_q[N-1-j].
- R5: Exactly one capture cycle follows shift-in, in which every element loads its func_d bit.
- R6: scan_out always shows element N-1. During the N shift-out cycles that follow the capture, cycle j presents captured bit N-1-j, and scan_in keeps feeding element 0.
- R7: done is high for exactly one cycle, the cycle after the last shift-out cycle (2N+2 cycles after the edge that sampled start), and the sequencer is then idle.
- R8: start is ignored while a test is in progress.
- R9: If overlap_en is high in the last shift-out cycle, the sequencer goes straight to another capture cycle instead of done. The N bits shifted in during that shift-out then form the next pattern, and a new shift-out follows.
- R10: Dropping test_mode during a test aborts it: at the next edge the sequencer is idle and the bank loads func_d, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| test_mode | input | 1 | 1 = scan test operation, 0 = parallel register |
| start | input | 1 | Request one scan test (sampled in idle) |
| overlap_en | input | 1 | Chain the next test onto the current shift-out |
| scan_in | input | 1 | Serial test data into element 0 |
| func_d | input | N | Functional parallel inputs, one per element |
| scan_out | output | 1 | Serial data from element N-1 |
| func_q | output | N | Parallel contents of the chain |
| done | output | 1 | One-cycle pulse when a test finishes |

## Verification
The checker looks at every cycle for the per-edge rules that can be seen in one step: the reset result, parallel loading in functional mode, holding in idle, the shift rule in both shift phases, loading on the capture cycle, done being a single pulse, and no done after functional mode. Other behaviour depends on counting cycles against the chain length, and only the bench scenarios can show it. This covers the exact number of shift cycles, which serial bit lands in which element, the order in which captured bits leave the serial output, when done arrives, the overlapped second test, and the abort paths. The bench shows these by driving whole patterns and comparing them with a model of the surrounding logic.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_SHIFT_IN  = 3'd1,
    ST_CAPTURE   = 3'd2,
    ST_SHIFT_OUT = 3'd3,
    ST_DONE      = 3'd4
  } seq_state_e;
endpackage

// File: rtl/scan_seq_cell.sv
// One chain element: a select between functional and serial data, a load enable, one flop.
module scan_seq_cell (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  logic scan_sel,
  input  logic func_bit,
  input  logic scan_bit,
  output logic q
);
  logic nxt;

  always_comb nxt = scan_sel ? scan_bit : func_bit;

  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (load_en) q <= nxt;
  end
endmodule

// File: rtl/scan_seq_ctrl.sv
// Phase controller: idle -> shift-in (N) -> capture (1) -> shift-out (N) -> done.
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       test_mode,
  input  logic       start,
  input  logic       overlap_en,
  output seq_state_e state,
  output logic       shift_en,
  output logic       capture_en,
  output logic       done
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  seq_state_e      state_n;
  logic [CW-1:0]   cnt, cnt_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    unique case (state)
      ST_IDLE: if (start) begin
        state_n = ST_SHIFT_IN;
        cnt_n   = '0;
      end
      ST_SHIFT_IN: begin
        if (cnt == LAST) begin
          state_n = ST_CAPTURE;
          cnt_n   = '0;
        end else cnt_n = cnt + 1'b1;
      end
      ST_CAPTURE: begin
        state_n = ST_SHIFT_OUT;
        cnt_n   = '0;
      end
      ST_SHIFT_OUT: begin
        if (cnt == LAST) begin
          state_n = overlap_en ? ST_CAPTURE : ST_DONE;
          cnt_n   = '0;
        end else cnt_n = cnt + 1'b1;
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !test_mode) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

  always_comb begin
    shift_en   = test_mode && (state == ST_SHIFT_IN || state == ST_SHIFT_OUT);
    capture_en = test_mode && (state == ST_CAPTURE);
    done       = (state == ST_DONE);
  end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_mode,
  input  logic         start,
  input  logic         overlap_en,
  input  logic         scan_in,
  input  logic [N-1:0] func_d,
  output logic         scan_out,
  output logic [N-1:0] func_q,
  output logic         done
);
  seq_state_e   state_q;
  logic         shift_en, capture_en;
  logic         load_en, scan_sel;
  logic [N-1:0] chain_q, serial_w;

  scan_seq_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .test_mode  (test_mode),
    .start      (start),
    .overlap_en (overlap_en),
    .state      (state_q),
    .shift_en   (shift_en),
    .capture_en (capture_en),
    .done       (done)
  );

  // Functional mode loads every cycle; test mode loads only on shift or capture.
  always_comb begin
    scan_sel = shift_en;
    load_en  = !test_mode || shift_en || capture_en;
  end

  for (genvar i = 0; i < N; i++) begin : g_elem
    if (i == 0) begin : g_head
      assign serial_w[i] = scan_in;
    end else begin : g_link
      assign serial_w[i] = chain_q[i-1];
    end
    scan_seq_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .load_en  (load_en),
      .scan_sel (scan_sel),
      .func_bit (func_d[i]),
      .scan_bit (serial_w[i]),
      .q        (chain_q[i])
    );
  end

  assign func_q   = chain_q;
  assign scan_out = chain_q[N-1];
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk
  import scan_seq_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         test_mode,
  input logic         start,
  input logic         scan_in,
  input logic [N-1:0] func_d,
  input logic [N-1:0] func_q,
  input logic         done,
  input seq_state_e   state
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (func_q == '0 && !done));

  a_r2_parallel_load: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> func_q == $past(func_d));

  a_r2_no_done_functional: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> !done);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (test_mode && state == ST_IDLE) |=> $stable(func_q));

  a_r4_shift_in_step: assert property (@(posedge clk) disable iff (rst)
    (test_mode && state == ST_SHIFT_IN) |=>
      func_q == {$past(func_q[N-2:0]), $past(scan_in)});

  a_r5_capture_load: assert property (@(posedge clk) disable iff (rst)
    (test_mode && state == ST_CAPTURE) |=> func_q == $past(func_d));

  a_r6_shift_out_step: assert property (@(posedge clk) disable iff (rst)
    (test_mode && state == ST_SHIFT_OUT) |=>
      func_q == {$past(func_q[N-2:0]), $past(scan_in)});

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (test_mode && start && state == ST_SHIFT_IN) |=> state != ST_IDLE);
endmodule

bind scan_seq_top scan_seq_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .test_mode (test_mode),
  .start     (start),
  .scan_in   (scan_in),
  .func_d    (func_d),
  .func_q    (func_q),
  .done      (done),
  .state     (state_q)
);

// File: tb/scan_seq_top_test.sv
module scan_seq_top_test;
  localparam int N = 8;
  localparam int NV = 6;
  // {pattern, logic key, next pattern, overlap}
  localparam logic [3*N:0] VEC [NV] = '{
    {8'hA5, 8'h00, 8'h00, 1'b0},
    {8'h3C, 8'hFF, 8'h00, 1'b0},
    {8'h01, 8'h81, 8'hC3, 1'b1},
    {8'h80, 8'h5A, 8'h00, 1'b0},
    {8'hFF, 8'h0F, 8'h7E, 1'b1},
    {8'h00, 8'hF0, 8'h00, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         test_mode = 1'b0;
  logic         start = 1'b0;
  logic         overlap_en = 1'b0;
  logic         scan_in = 1'b0;
  logic [N-1:0] key = '0;
  logic [N-1:0] func_d;
  logic         scan_out;
  logic [N-1:0] func_q;
  logic         done;
  int           n_chk = 0;
  int           n_bad = 0;

  always #5 clk = ~clk;

  // Model of the surrounding logic: rotate left by one, then XOR a key.
  function automatic logic [N-1:0] logic_fn(logic [N-1:0] q, logic [N-1:0] k);
    return {q[N-2:0], q[N-1]} ^ k;
  endfunction

  assign func_d = logic_fn(func_q, key);

  scan_seq_top #(.N(N)) uut (
    .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
    .overlap_en(overlap_en), .scan_in(scan_in), .func_d(func_d),
    .scan_out(scan_out), .func_q(func_q), .done(done)
  );

  task automatic check(input logic ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Start a test and shift in pat; returns in the capture cycle.
  task automatic shift_in(input logic [N-1:0] pat, input logic hold_start);
    start = 1'b1;
    @(negedge clk);
    for (int j = 0; j < N; j++) begin
      start   = hold_start;
      scan_in = pat[N-1-j];
      check(!done, "R8 no done while shifting", {7'b0, done}, '0);
      @(negedge clk);
    end
    start = 1'b0;
    check(func_q == pat, "R4 pattern loaded", func_q, pat);
  endtask

  // Called in the first shift-out cycle; returns in the cycle after the last one.
  task automatic shift_out(input logic [N-1:0] cap, input logic [N-1:0] nxt,
                           input logic ovl);
    check(func_q == cap, "R5 capture loaded", func_q, cap);
    for (int j = 0; j < N; j++) begin
      check(scan_out == cap[N-1-j], "R6 serial response bit",
            {7'b0, scan_out}, {7'b0, cap[N-1-j]});
      scan_in    = nxt[N-1-j];
      overlap_en = ovl;
      @(negedge clk);
    end
    overlap_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] pat, nxt, cap, snap;
    logic         ovl;
    repeat (3) @(negedge clk);
    check(func_q == '0, "R1 reset clears chain", func_q, '0);
    check(!done, "R1 reset done low", {7'b0, done}, '0);

    // Functional mode with start asserted: parallel load, start ignored.
    key = 8'h96;
    rst = 1'b0;
    start = 1'b1;
    for (int c = 0; c < 4; c++) begin
      snap = func_q;
      @(negedge clk);
      check(func_q == logic_fn(snap, key), "R2 parallel load", func_q, logic_fn(snap, key));
      check(!done, "R2 start ignored", {7'b0, done}, '0);
    end
    start = 1'b0;

    // Enter test mode idle: contents hold.
    test_mode = 1'b1;
    snap = func_q;
    repeat (4) @(negedge clk);
    check(func_q == snap, "R3 idle hold", func_q, snap);

    // Table of scan tests.
    for (int v = 0; v < NV; v++) begin
      {pat, key, nxt, ovl} = VEC[v];
      shift_in(pat, v[0]);
      cap = logic_fn(pat, key);
      @(negedge clk);
      shift_out(cap, nxt, ovl);
      if (ovl) begin
        check(func_q == nxt, "R9 overlap pattern loaded", func_q, nxt);
        check(!done, "R9 no done on overlap", {7'b0, done}, '0);
        cap = logic_fn(nxt, key);
        @(negedge clk);
        shift_out(cap, '0, 1'b0);
      end
      check(done, "R7 done pulse", {7'b0, done}, 8'h01);
      @(negedge clk);
      check(!done, "R7 done single cycle", {7'b0, done}, '0);
      snap = func_q;
      @(negedge clk);
      check(func_q == snap, "R7 idle after done", func_q, snap);
    end

    // Abort by dropping test_mode mid shift-in.
    key = 8'h3C;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    scan_in = 1'b1;
    repeat (3) @(negedge clk);
    test_mode = 1'b0;
    snap = func_q;
    @(negedge clk);
    check(func_q == logic_fn(snap, key), "R10 abort loads func_d", func_q, logic_fn(snap, key));
    test_mode = 1'b1;
    snap = func_q;
    for (int c = 0; c < 2*N+4; c++) begin
      @(negedge clk);
      check(!done && func_q == snap, "R10 aborted test stays idle", func_q, snap);
    end

    // Reset mid-test.
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(func_q == '0, "R1 reset mid-test", func_q, '0);
    rst = 1'b0;
    for (int c = 0; c < 2*N+4; c++) begin
      @(negedge clk);
      check(!done && func_q == '0, "R1 idle after reset", func_q, '0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule